// File: doc/BRIEF.md
# Serial Gain Word Loader

This block is the control port for a digitally programmed gain stage. Three wires carry the setting: a serial data line, a serial clock, and an active-low load window. While the window is open (low), each rising edge of the serial clock shifts one data bit into an internal register, most significant bit first. When the window closes (low-to-high), the assembled word is copied into a holding register. That register drives the 8-bit parallel gain code. Serial clock activity outside the window is ignored.

Everything runs on one system clock. The serial clock, serial data and window inputs are brought into that domain through two-flop synchronizers and then edge-detected. None of them is used as a clock. A bit counter restarts each time the window opens. A status flag, taken at the close of the window, reports whether exactly eight bits arrived. A power-down input is registered onto a power-down status output and does not disturb the stored gain code.

Top module: `gain_word_loader`

## Requirements
- R1: After reset the gain code output is 0x00 (minimum gain), the word-complete flag is 0 and the power-down output is 0.
- R2: While the window input is low, each rising edge of the serial clock shifts the serial data bit into the register at bit 0, moving earlier bits toward bit 7. The first bit sent therefore ends in bit 7 after eight bits.
- R3: While the window input is low, the gain code output keeps the value it had before the window opened.
- R4: Within three system clock cycles of the window input rising, the gain code output equals the shift register contents.
- R5: Serial clock edges while the window input is high leave the shift register unchanged. A later load with zero bits then outputs the previous word again.
- R6: At each close of the window, the word-complete flag becomes 1 if exactly eight rising serial clock edges were seen since the window opened. Otherwise it becomes 0. Counts of 0, 3 and 9 all give 0.
- R7: If the window closes after fewer or more than eight bits, the gain code still takes the register contents: the previous register value shifted left by the bit count, with the new bits in the low positions, truncated to 8 bits.
- R8: The power-down output equals the power-down input delayed by one system clock. Raising power-down leaves the gain code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock, sampled and edge-detected |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| load_n_i | input | 1 | Active-low load window |
| pwr_down_i | input | 1 | Power-down request, active high |
| gain_code_o | output | 8 | Applied gain code |
| word_ok_o | output | 1 | Exactly eight bits arrived in the last window |
| pwr_down_o | output | 1 | Power-down status |

## Verification
The bench checks the gain code part-way through a load. A design with a transparent latch would show a half-shifted word there. It sends serial clock bursts while the window is high and then runs an empty load. A design that shifts outside the window would output altered bits at that point. Loads of three and nine bits check both the truncated register value and a cleared completion flag. A counter that wraps would wrongly report a nine-bit load as complete. A power-down request is also checked to see that the gain code stays put and the status follows with a one-cycle delay.

// File: rtl/gwl_pkg.sv
package gwl_pkg;
    localparam int unsigned NUM_CH = 3;

    typedef enum int unsigned {
        CH_SCLK  = 0,
        CH_SDAT  = 1,
        CH_LOADN = 2
    } ch_e;
endpackage

// File: rtl/gwl_sync.sv
module gwl_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
        logic [N-1:0]             prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pipe <= {STAGES{RST_VAL}};
            st_q.prev <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.pipe[STAGES-1];

    for (genvar c = 0; c < N; c++) begin : g_edge
        assign rise_o[c] =  st_q.pipe[STAGES-1][c] & ~st_q.prev[c];
        assign fall_o[c] = ~st_q.pipe[STAGES-1][c] &  st_q.prev[c];
    end
endmodule

// File: rtl/gwl_shifter.sv
module gwl_shifter #(
    parameter int unsigned W  = 8,
    parameter int unsigned CW = $clog2(W + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_open_i,
    input  logic          sclk_rise_i,
    input  logic          sdat_i,
    input  logic          win_start_i,
    output logic [W-1:0]  sreg_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] CNT_MAX = CW'(W + 1);

    typedef struct packed {
        logic [W-1:0]  sreg;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [CW-1:0] base;
        st_d = st_q;
        base = win_start_i ? '0 : st_q.cnt;
        st_d.cnt = base;
        if (win_open_i && sclk_rise_i) begin
            st_d.sreg = {st_q.sreg[W-2:0], sdat_i};
            if (base != CNT_MAX) begin
                st_d.cnt = base + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sreg_o = st_q.sreg;
    assign cnt_o  = st_q.cnt;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_MAX); // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_start_i && !sclk_rise_i) |=> (cnt_o == '0)); // R6
endmodule

// File: rtl/gwl_latch.sv
module gwl_latch #(
    parameter int unsigned W  = 8,
    parameter int unsigned CW = $clog2(W + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic [W-1:0]  sreg_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          pd_i,
    output logic [W-1:0]  gain_o,
    output logic          ok_o,
    output logic          pd_o
);
    localparam logic [CW-1:0] CNT_FULL = CW'(W);

    typedef struct packed {
        logic [W-1:0] gain;
        logic         ok;
        logic         pd;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.pd = pd_i;
        if (upd_i) begin
            st_d.gain = sreg_i;
            st_d.ok   = (cnt_i == CNT_FULL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain_o = st_q.gain;
    assign ok_o   = st_q.ok;
    assign pd_o   = st_q.pd;

    AST_OK_NEEDS_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> ($past(cnt_i) == CNT_FULL)); // R6
    AST_PD_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_i && !upd_i) |=> $stable(gain_o)); // R8
endmodule

// File: rtl/gain_word_loader.sv
module gain_word_loader #(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             load_n_i,
    input  logic             pwr_down_i,
    output logic [WIDTH-1:0] gain_code_o,
    output logic             word_ok_o,
    output logic             pwr_down_o
);
    import gwl_pkg::*;

    localparam int unsigned CW = $clog2(WIDTH + 2);
    localparam logic [NUM_CH-1:0] SYNC_RST = NUM_CH'(1) << CH_LOADN;

    logic [NUM_CH-1:0] raw, lvl, rise, fall;
    logic [WIDTH-1:0]  sreg;
    logic [CW-1:0]     cnt;

    always_comb begin
        raw           = '0;
        raw[CH_SCLK]  = ser_clk_i;
        raw[CH_SDAT]  = ser_dat_i;
        raw[CH_LOADN] = load_n_i;
    end

    gwl_sync #(.N(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .lvl_o   (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    gwl_shifter #(.W(WIDTH), .CW(CW)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_open_i  (~lvl[CH_LOADN]),
        .sclk_rise_i (rise[CH_SCLK]),
        .sdat_i      (lvl[CH_SDAT]),
        .win_start_i (fall[CH_LOADN]),
        .sreg_o      (sreg),
        .cnt_o       (cnt)
    );

    gwl_latch #(.W(WIDTH), .CW(CW)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_i  (rise[CH_LOADN]),
        .sreg_i (sreg),
        .cnt_i  (cnt),
        .pd_i   (pwr_down_i),
        .gain_o (gain_code_o),
        .ok_o   (word_ok_o),
        .pd_o   (pwr_down_o)
    );

    AST_HOLD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl[CH_LOADN] |=> $stable(gain_code_o)); // R3
    AST_TAKE_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise[CH_LOADN] |=> (gain_code_o == $past(sreg))); // R4
    AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        lvl[CH_LOADN] |=> $stable(sreg)); // R5
    AST_MSB_ENTERS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl[CH_LOADN] && rise[CH_SCLK]) |=> (sreg[0] == $past(lvl[CH_SDAT]))); // R2
endmodule

// File: tb/sim_gain_word_loader.sv
module sim_gain_word_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       sdat = 1'b0;
    logic       load_n = 1'b1;
    logic       pd = 1'b0;
    logic [7:0] gain;
    logic       ok;
    logic       pd_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] model_sreg = 8'h00;

    typedef struct {
        logic [7:0] gain;
        logic       ok;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    always #2.5 clk = ~clk;

    gain_word_loader u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk_i   (sclk),
        .ser_dat_i   (sdat),
        .load_n_i    (load_n),
        .pwr_down_i  (pd),
        .gain_code_o (gain),
        .word_ok_o   (ok),
        .pwr_down_o  (pd_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bit(input logic b);
        sdat = b;
        wait_cyc(4);
        sclk = 1'b1;
        wait_cyc(4);
        sclk = 1'b0;
        wait_cyc(4);
    endtask

    // Driver: send n bits (bit n-1 first), close window, push expectation
    task automatic load(input logic [15:0] val, input int n, input string tag);
        logic [7:0] held;
        exp_t e;
        held = gain;
        load_n = 1'b0;
        wait_cyc(4);
        for (int i = n - 1; i >= 0; i--) begin
            pulse_bit(val[i]);
            model_sreg = {model_sreg[6:0], val[i]};
        end
        check({"R3 hold during load ", tag}, gain, held);
        load_n = 1'b1;
        e.gain = model_sreg;
        e.ok   = (n == 8);
        e.tag  = tag;
        exp_q.push_back(e);
        wait_cyc(6);
        -> chk_ev;
        wait_cyc(2);
    endtask

    // Monitor: pop and compare when the driver signals completion
    initial begin
        forever begin
            exp_t e;
            @(chk_ev);
            @(negedge clk);
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check({"R4 gain ", e.tag}, gain, e.gain);
                check({"R6 word flag ", e.tag}, ok, e.ok);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(5);
        check("R1 reset gain", gain, 0);
        check("R1 reset flag", ok, 0);
        check("R1 reset pd", pd_o, 0);
        rst_n = 1'b1;
        wait_cyc(4);

        load(16'h00A5, 8, "R2 word A5");
        load(16'h003C, 8, "R2 word 3C");

        // R5: serial edges with the window closed must not shift
        for (int k = 0; k < 5; k++) pulse_bit(1'b1);
        check("R5 gain after idle pulses", gain, 8'h3C);
        load(16'h0000, 0, "R5 empty load");

        load(16'h0005, 3, "R7 three bits");
        load(16'h015A, 9, "R7 nine bits");

        // R8: power-down
        pd = 1'b1;
        @(negedge clk);
        check("R8 pd one cycle later", pd_o, 1);
        wait_cyc(3);
        check("R8 gain kept in power-down", gain, 8'h5A);
        pd = 1'b0;
        @(negedge clk);
        check("R8 pd release", pd_o, 0);

        load(16'h00FF, 8, "R2 word FF");
        load(16'h0000, 8, "R2 word 00");
        load(16'h0081, 8, "R2 word 81");

        wait_cyc(4);
        check("scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule